// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block is the return-address store of a small 8-bit processor core. It is a last-in first-out memory of 16 entries, each 15 bits wide, built as its own storage so that it takes no room in data memory. The core pushes a return address with a strobe on a call and pops it with a strobe on a return. The most recent entry is always visible on a combinational top-of-stack output.

Misuse is recorded and never corrupts the stored entries. A push into a full stack sets a sticky overflow flag, and a pop from an empty stack sets a sticky underflow flag. When the fault-reset enable is high, either fault also produces a one-cycle reset request for the chip's reset generator. That generator later drives the synchronous system reset, which empties the stack but keeps both flags, so software can still see why the core restarted. Software clears the flags with a clear strobe. Only the power-on reset also clears them.

Top module: `retstack`

## Requirements
- R1: Pushes store 15-bit addresses in up to 16 entries. The `top_addr` output always shows the most recently pushed entry that has not been popped, so pops return the entries in reverse push order.
- R2: A push alone into a stack that already holds 16 entries sets `ovf_flag` at the next clock edge. It leaves every stored entry and the fill level unchanged.
- R3: A pop alone, or a push with a pop, on an empty stack sets `unf_flag` at the next clock edge. The stack stays empty, and `top_addr` reads 0 whenever the stack is empty.
- R4: A push and a pop in the same cycle on a non-empty stack replace the top entry with `push_addr` and leave the fill level unchanged. No flag is set, even when the stack is full.
- R5: Both flags are sticky. A flag stays 1 until a cycle with `clr_flags` high. If a fault occurs in the same cycle as the clear, the fault wins and the flag reads 1 afterwards.
- R6: `rst_req` is high for exactly the one cycle that follows a cycle in which an overflow or underflow occurred with `fault_rst_en` high. It is never high in any other cycle.
- R7: While `sys_rst` is high, the stack empties and pushes and pops are ignored. `ovf_flag` and `unf_flag` are not cleared by it, and no fault is raised.
- R8: While `por_n` is low, the stack is empty, `top_addr` is 0, and `ovf_flag`, `unf_flag` and `rst_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the stack and the flags |
| sys_rst | input | 1 | Synchronous system reset; empties the stack and keeps the flags |
| push | input | 1 | Push strobe |
| push_addr | input | 15 | Return address to push |
| pop | input | 1 | Pop strobe |
| top_addr | output | 15 | Current top entry, 0 when the stack is empty |
| fault_rst_en | input | 1 | Turns a fault into a reset request |
| clr_flags | input | 1 | Software clear of both flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two pairs of functions can land in the same cycle. A push can coincide with a pop, and a fault can coincide with the software clear of the flags. The bench provokes both pairs on purpose, on a full stack, on an empty stack and on a partly filled stack. It also drives random traffic in which the four strobes overlap freely. A behavioural queue model predicts the top entry, both flags and the reset request after every edge, and the bench compares all four on every cycle. Any disagreement is attributed to the requirement that output belongs to.

// File: rtl/retstack.sv
module retstack #(
  parameter int DEPTH = 16,
  parameter int AW    = 15
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top_addr,
  input  logic          fault_rst_en,
  input  logic          clr_flags,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          rst_req
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [LW-1:0] lvl;

  wire empty   = (lvl == '0);
  wire full    = (lvl == LW'(DEPTH));
  wire act     = ~sys_rst;
  wire ovf_evt = act & push & ~pop & full;
  wire unf_evt = act & pop & empty;
  wire wr_new  = act & push & ~pop & ~full;
  wire repl    = act & push & pop & ~empty;
  wire rd_old  = act & pop & ~push & ~empty;

  wire [IW-1:0] top_idx = IW'(lvl - LW'(1));
  wire [IW-1:0] new_idx = IW'(lvl);

  assign top_addr = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (wr_new)    mem[new_idx] <= push_addr;
    else if (repl) mem[top_idx] <= push_addr;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       lvl <= '0;
    else if (sys_rst) lvl <= '0;
    else if (wr_new)  lvl <= lvl + LW'(1);
    else if (rd_old)  lvl <= lvl - LW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag & ~clr_flags) | ovf_evt;
      unf_flag <= (unf_flag & ~clr_flags) | unf_evt;
      rst_req  <= fault_rst_en & (ovf_evt | unf_evt);
    end
  end
endmodule

// File: rtl/retstack_chk.sv
module retstack_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 15,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          sys_rst,
  input logic          push,
  input logic          pop,
  input logic          fault_rst_en,
  input logic          clr_flags,
  input logic [AW-1:0] top_addr,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          rst_req,
  input logic [LW-1:0] lvl
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!por_n)
    lvl <= LW'(DEPTH));

  a_r2_full_push: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && push && !pop && lvl == LW'(DEPTH)) |=> (ovf_flag && $stable(lvl) && $stable(top_addr)));

  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && pop && lvl == '0) |=> (unf_flag && lvl == '0));

  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!por_n)
    (lvl == '0) |-> (top_addr == '0));

  a_r4_replace_level: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && push && pop && lvl != '0) |=> $stable(lvl));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (ovf_flag && !clr_flags) |=> ovf_flag);

  a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (unf_flag && !clr_flags) |=> unf_flag);

  a_r6_req_enabled: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(fault_rst_en));

  a_r7_sysrst_empty: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> (lvl == '0 && !rst_req));
endmodule

bind retstack retstack_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .push(push), .pop(pop),
  .fault_rst_en(fault_rst_en), .clr_flags(clr_flags), .top_addr(top_addr),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req), .lvl(lvl)
);

// File: tb/retstack_bench.sv
`timescale 1ns/1ps
module retstack_bench;
  localparam int DEPTH = 16;
  localparam int AW    = 15;

  logic clk = 0;
  logic por_n = 0, sys_rst = 0, push = 0, pop = 0, fault_rst_en = 0, clr_flags = 0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] top_addr;
  logic ovf_flag, unf_flag, rst_req;

  always #4 clk = ~clk;

  retstack #(.DEPTH(DEPTH), .AW(AW)) u_retstack (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .push(push), .push_addr(push_addr),
    .pop(pop), .top_addr(top_addr), .fault_rst_en(fault_rst_en), .clr_flags(clr_flags),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req));

  int checks = 0, errors = 0;
  int q[$];
  bit m_ovf = 0, m_unf = 0, m_req = 0;

  function automatic void chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic int m_top();
    return (q.size() == 0) ? 0 : q[$];
  endfunction

  task automatic compare(string tag);
    chk(tag, "top_addr R1", int'(top_addr), m_top());
    chk(tag, "ovf_flag R2", int'(ovf_flag), int'(m_ovf));
    chk(tag, "unf_flag R3", int'(unf_flag), int'(m_unf));
    chk(tag, "rst_req R6", int'(rst_req), int'(m_req));
  endtask

  task automatic step(string tag, bit pu, int a, bit po, bit clr, bit en, bit sr);
    bit f_o, f_u;
    @(negedge clk);
    push = pu; push_addr = AW'(a); pop = po; clr_flags = clr; fault_rst_en = en; sys_rst = sr;
    @(posedge clk);
    f_o = 0; f_u = 0;
    if (sr) q.delete();
    else if (pu && po) begin
      if (q.size() == 0) f_u = 1; else q[$] = a & 32'h7fff;
    end else if (pu) begin
      if (q.size() == DEPTH) f_o = 1; else q.push_back(a & 32'h7fff);
    end else if (po) begin
      if (q.size() == 0) f_u = 1; else void'(q.pop_back());
    end
    m_ovf = (m_ovf && !clr) || f_o;
    m_unf = (m_unf && !clr) || f_u;
    m_req = en && (f_o || f_u);
    #2;
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 0; push = 0; pop = 0; clr_flags = 0; sys_rst = 0; fault_rst_en = 0;
    q.delete(); m_ovf = 0; m_unf = 0; m_req = 0;
    #1 compare("R8");
    @(negedge clk);
    por_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_por();
    idle("R8");
    step("R3", 0, 0, 1, 0, 0, 0);
    idle("R5");
    step("R5", 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step("R1", 1, 16'h1000 + i * 37, 0, 0, 0, 0);
    step("R2", 1, 16'h7abc, 0, 0, 1, 0);
    idle("R6");
    step("R4", 1, 16'h0555, 1, 0, 1, 0);
    step("R2", 1, 16'h0666, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) step("R1", 0, 0, 1, 0, 0, 0);
    step("R5", 0, 0, 1, 1, 1, 0);
    step("R5", 0, 0, 0, 1, 0, 0);
    step("R4", 1, 16'h0123, 1, 0, 1, 0);
    idle("R6");
    step("R1", 1, 16'h0042, 0, 0, 0, 0);
    step("R1", 1, 16'h0043, 0, 0, 0, 0);
    step("R4", 1, 16'h7fff, 1, 0, 0, 0);
    step("R7", 1, 16'h0099, 1, 0, 1, 1);
    step("R7", 0, 0, 1, 0, 1, 1);
    idle("R7");
    step("R3", 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R1", 1, 16'h2000 + i, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1);
    idle("R7");
    for (int i = 0; i < 600; i++) begin
      int r = $urandom;
      step("R1", r[0] | r[1], r[30:16], r[2] & r[3], r[4] & r[5] & r[6], r[7], (r[15:8] == 8'h11));
    end
    do_por();
    idle("R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule